// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block predicts, for a memory instruction about to be scheduled, whether it should wait for an older store that is still in flight, and if so which one. Prediction goes through two levels. A PC-indexed table gives a store set ID. A second table, indexed by that ID, gives the sequence number of the most recently fetched store in the set. Both tables keep a valid bit per entry.

The pipeline reports ordering violations (older store PC, younger load PC), and the block joins the two PCs into one store set. Stores are announced at insert time. The block tracks them in a small content-addressable list until they issue or are squashed. When they leave, the block retires their last-fetched entry, but only if that entry still names them. A lookup counter wipes all valid bits after a configured number of predictions, so that old sets do not pile up and over-serialise memory traffic. A global clear resets everything.

Top module: `mdp_storeset`

## Requirements
- R1: The ID table index is PC bits [PC_OFFSET +: log2(SSIT_DEPTH)]. With the defaults (offset 2, 64 entries) this is (PC >> 2) & 63, so PCs that differ only above bit 7 share an entry.
- R2: A violation places the store PC and the load PC in one common set. When neither has a valid ID, both receive (store PC XOR (store PC >> 10)) modulo LFST_DEPTH.
- R3: When exactly one of the two PCs has a valid ID, the other PC takes that ID.
- R4: When both PCs have valid IDs, both take the numerically smaller ID.
- R5: A store insert whose PC has a valid ID writes that ID's last-fetched entry with the store's sequence number and marks it valid. A store whose PC has no valid ID changes nothing.
- R6: A lookup gives rsp_valid_o = 1 two rising edges after the request. rsp_seq_o holds the last-fetched sequence number when the PC's ID and that ID's entry are both valid, and 0 otherwise.
- R7: An insert with ins_store_i = 0 (a load) changes no state.
- R8: A store issue (iss_store_i = 1) removes the matching store from the in-flight list. It invalidates that store's last-fetched entry only if the entry still holds that store's sequence number. An issue with iss_store_i = 0 has no effect.
- R9: A squash removes every tracked store of the given thread whose sequence number is greater than the given one, retiring the last-fetched entries those stores still hold. Older stores and other threads are untouched.
- R10: The in-flight list holds LIST_DEPTH (default 8) stores. ins_ready_o is low while it is full, and an insert offered while ins_ready_o is low is ignored.
- R11: Each lookup response counts one prediction. The response that reaches CLEAR_PERIOD predictions still carries a pre-wipe result. At that same edge all valid bits of both tables are cleared and the count restarts at zero.
- R12: clr_i empties both tables, the in-flight list and the prediction count. Every other request in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Global clear of all predictor state |
| vio_valid_i | input | 1 | Violation report strobe |
| vio_st_pc_i | input | PC_W | PC of the older store in the violation |
| vio_ld_pc_i | input | PC_W | PC of the younger load in the violation |
| ins_valid_i | input | 1 | Insert request strobe |
| ins_store_i | input | 1 | Insert is a store (1) or a load (0) |
| ins_pc_i | input | PC_W | PC of the inserted instruction |
| ins_seq_i | input | SEQ_W | Sequence number of the inserted instruction |
| ins_tid_i | input | TID_W | Thread of the inserted instruction |
| ins_ready_o | output | 1 | In-flight list has room for a store |
| lk_valid_i | input | 1 | Lookup request strobe |
| lk_pc_i | input | PC_W | PC to predict for |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_seq_o | output | SEQ_W | Predicted producer store sequence number, 0 if none |
| iss_valid_i | input | 1 | Issue notification strobe |
| iss_store_i | input | 1 | Issued instruction is a store |
| iss_seq_i | input | SEQ_W | Sequence number of the issued instruction |
| sq_valid_i | input | 1 | Squash request strobe |
| sq_seq_i | input | SEQ_W | Squash boundary; younger stores are dropped |
| sq_tid_i | input | TID_W | Thread being squashed |

## Verification
The bench builds store sets through each merge case. It tells the cases apart by which store a later lookup names: a design that let the larger ID win, or that rehashed when one side was valid, would point the load at an empty entry and return 0. Issue and squash are driven against stores that are not the newest in their set. A design that cleared entries without checking ownership would drop the prediction for a younger store that is still live. Squash boundaries on both sides of the stored numbers, and on the wrong thread, check the strict comparison and the thread match. The bench fills the list and offers an extra insert while full, to catch a design that overwrites a slot. Lookups are run right up to the clear period, to catch a wipe one prediction early or late.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  // How a violation resolves the store set ID, from {store valid, load valid}
  typedef enum logic [1:0] {
    MERGE_FRESH     = 2'b00,
    MERGE_USE_LOAD  = 2'b01,
    MERGE_USE_STORE = 2'b10,
    MERGE_MIN       = 2'b11
  } merge_e;
endpackage

// File: rtl/mdp_id_table.sv
module mdp_id_table
  import mdp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int SSIT_DEPTH = 64,
  parameter int LFST_DEPTH = 16,
  parameter int PC_OFFSET  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wipe_i,
  input  logic                          vio_valid_i,
  input  logic [PC_W-1:0]               vio_st_pc_i,
  input  logic [PC_W-1:0]               vio_ld_pc_i,
  input  logic [PC_W-1:0]               rd_pc_a_i,
  output logic                          rd_hit_a_o,
  output logic [$clog2(LFST_DEPTH)-1:0] rd_id_a_o,
  input  logic [PC_W-1:0]               rd_pc_b_i,
  output logic                          rd_hit_b_o,
  output logic [$clog2(LFST_DEPTH)-1:0] rd_id_b_o
);
  localparam int IDX_W = $clog2(SSIT_DEPTH);
  localparam int ID_W  = $clog2(LFST_DEPTH);

  logic [ID_W-1:0]       id_q [SSIT_DEPTH];
  logic [SSIT_DEPTH-1:0] vld_q;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[PC_OFFSET +: IDX_W];
  endfunction

  function automatic logic [ID_W-1:0] hash_id(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] mix;
    mix = pc ^ (pc >> 10);
    return ID_W'(mix % PC_W'(LFST_DEPTH));
  endfunction

  logic [IDX_W-1:0] st_idx, ld_idx;
  logic             st_v, ld_v;
  logic [ID_W-1:0]  st_id, ld_id, new_id;
  merge_e           mcase;

  always_comb begin
    st_idx = idx_of(vio_st_pc_i);
    ld_idx = idx_of(vio_ld_pc_i);
    st_v   = vld_q[st_idx];
    ld_v   = vld_q[ld_idx];
    st_id  = id_q[st_idx];
    ld_id  = id_q[ld_idx];
    mcase  = merge_e'({st_v, ld_v});
    unique case (mcase)
      MERGE_FRESH:     new_id = hash_id(vio_st_pc_i);
      MERGE_USE_LOAD:  new_id = ld_id;
      MERGE_USE_STORE: new_id = st_id;
      default:         new_id = (st_id < ld_id) ? st_id : ld_id;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || wipe_i) begin
      vld_q <= '0;
    end else if (vio_valid_i) begin
      vld_q[st_idx] <= 1'b1;
      vld_q[ld_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (vio_valid_i) begin
      id_q[st_idx] <= new_id;
      id_q[ld_idx] <= new_id;
    end
  end

  assign rd_hit_a_o = vld_q[idx_of(rd_pc_a_i)];
  assign rd_id_a_o  = id_q[idx_of(rd_pc_a_i)];
  assign rd_hit_b_o = vld_q[idx_of(rd_pc_b_i)];
  assign rd_id_b_o  = id_q[idx_of(rd_pc_b_i)];

  logic rd_pc_unused;
  assign rd_pc_unused = ^{rd_pc_a_i, rd_pc_b_i};

  // R2: a violation leaves both PCs valid and sharing one ID
  assert_vio_common_set_R2: assert property (@(posedge clk) disable iff (rst)
    (vio_valid_i && !wipe_i) |=>
      (vld_q[$past(st_idx)] && vld_q[$past(ld_idx)] &&
       id_q[$past(st_idx)] == id_q[$past(ld_idx)]));

  // R4: when both sides were valid, the merged ID never exceeds either old ID
  assert_vio_min_R4: assert property (@(posedge clk) disable iff (rst)
    (vio_valid_i && !wipe_i && st_v && ld_v) |=>
      (id_q[$past(st_idx)] <= $past(st_id) && id_q[$past(st_idx)] <= $past(ld_id)));
endmodule

// File: rtl/mdp_last_store.sv
module mdp_last_store #(
  parameter int SEQ_W      = 16,
  parameter int LFST_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wipe_i,
  input  logic                          wr_i,
  input  logic [$clog2(LFST_DEPTH)-1:0] wr_id_i,
  input  logic [SEQ_W-1:0]              wr_seq_i,
  input  logic [LFST_DEPTH-1:0]         drop_mask_i,
  input  logic [$clog2(LFST_DEPTH)-1:0] rd_id_i,
  output logic                          rd_hit_o,
  output logic [SEQ_W-1:0]              rd_seq_o
);
  localparam int ID_W = $clog2(LFST_DEPTH);

  logic [SEQ_W-1:0]      seq_mem [LFST_DEPTH];
  logic [LFST_DEPTH-1:0] vld_q;
  logic [LFST_DEPTH-1:0] vld_nxt;

  // RAM-style data: one write port, one synchronous read port
  always_ff @(posedge clk) begin
    if (wr_i) seq_mem[wr_id_i] <= wr_seq_i;
    rd_seq_o <= seq_mem[rd_id_i];
  end

  always_comb begin
    vld_nxt = vld_q & ~drop_mask_i;
    if (wr_i) vld_nxt[wr_id_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || wipe_i) vld_q <= '0;
    else               vld_q <= vld_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_hit_o <= 1'b0;
    else     rd_hit_o <= vld_q[rd_id_i];
  end

  // R5: a written entry is valid on the next cycle
  assert_write_marks_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wipe_i) |=> vld_q[$past(wr_id_i)]);

  // R11: a wipe leaves no valid entry
  assert_wipe_empties_R11: assert property (@(posedge clk) disable iff (rst)
    wipe_i |=> (vld_q == '0));

  logic [ID_W-1:0] id_w_unused;
  assign id_w_unused = '0;
endmodule

// File: rtl/mdp_inflight.sv
module mdp_inflight #(
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 1,
  parameter int LFST_DEPTH = 16,
  parameter int DEPTH      = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr_i,
  input  logic                          alloc_i,
  input  logic [SEQ_W-1:0]              alloc_seq_i,
  input  logic [TID_W-1:0]              alloc_tid_i,
  input  logic [$clog2(LFST_DEPTH)-1:0] alloc_id_i,
  input  logic                          iss_i,
  input  logic [SEQ_W-1:0]              iss_seq_i,
  input  logic                          sq_i,
  input  logic [SEQ_W-1:0]              sq_seq_i,
  input  logic [TID_W-1:0]              sq_tid_i,
  output logic                          full_o,
  output logic [LFST_DEPTH-1:0]         drop_mask_o
);
  localparam int ID_W   = $clog2(LFST_DEPTH);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] own_q;   // entry is the current holder of its last-fetched slot
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [TID_W-1:0] tid_q [DEPTH];
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [DEPTH-1:0] rm;
  logic [SLOT_W-1:0] free_slot;

  for (genvar e = 0; e < DEPTH; e++) begin : g_match
    assign rm[e] = v_q[e] &&
                   ((iss_i && seq_q[e] == iss_seq_i) ||
                    (sq_i && tid_q[e] == sq_tid_i && seq_q[e] > sq_seq_i));
  end

  always_comb begin
    free_slot = '0;
    for (int e = DEPTH - 1; e >= 0; e--)
      if (!v_q[e]) free_slot = SLOT_W'(e);
  end

  always_comb begin
    drop_mask_o = '0;
    for (int e = 0; e < DEPTH; e++)
      if (rm[e] && own_q[e]) drop_mask_o[id_q[e]] = 1'b1;
  end

  assign full_o = &v_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      v_q   <= '0;
      own_q <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (alloc_i && free_slot == SLOT_W'(e)) begin
          v_q[e]   <= 1'b1;
          own_q[e] <= 1'b1;
        end else begin
          if (rm[e]) v_q[e] <= 1'b0;
          if (alloc_i && id_q[e] == alloc_id_i) own_q[e] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (alloc_i && free_slot == SLOT_W'(e)) begin
        seq_q[e] <= alloc_seq_i;
        tid_q[e] <= alloc_tid_i;
        id_q[e]  <= alloc_id_i;
      end
    end
  end

  // R10: nothing is placed into a full list
  assert_alloc_room_R10: assert property (@(posedge clk) disable iff (rst)
    alloc_i |-> !full_o);

  // R12: a global clear empties the list
  assert_clear_empty_R12: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (v_q == '0));
endmodule

// File: rtl/mdp_storeset.sv
module mdp_storeset #(
  parameter int PC_W         = 32,
  parameter int SEQ_W        = 16,
  parameter int TID_W        = 1,
  parameter int SSIT_DEPTH   = 64,
  parameter int LFST_DEPTH   = 16,
  parameter int LIST_DEPTH   = 8,
  parameter int PC_OFFSET    = 2,
  parameter int CLEAR_PERIOD = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             vio_valid_i,
  input  logic [PC_W-1:0]  vio_st_pc_i,
  input  logic [PC_W-1:0]  vio_ld_pc_i,
  input  logic             ins_valid_i,
  input  logic             ins_store_i,
  input  logic [PC_W-1:0]  ins_pc_i,
  input  logic [SEQ_W-1:0] ins_seq_i,
  input  logic [TID_W-1:0] ins_tid_i,
  output logic             ins_ready_o,
  input  logic             lk_valid_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  output logic             rsp_valid_o,
  output logic [SEQ_W-1:0] rsp_seq_o,
  input  logic             iss_valid_i,
  input  logic             iss_store_i,
  input  logic [SEQ_W-1:0] iss_seq_i,
  input  logic             sq_valid_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  input  logic [TID_W-1:0] sq_tid_i
);
  localparam int ID_W  = $clog2(LFST_DEPTH);
  localparam int CNT_W = $clog2(CLEAR_PERIOD + 1);

  logic            lk_hit, ins_hit, lf_hit, list_full;
  logic [ID_W-1:0] lk_id, ins_id;
  logic [SEQ_W-1:0] lf_seq;
  logic [LFST_DEPTH-1:0] drop_mask;
  logic            vio_go, ins_go, lk_go, iss_go, sq_go;
  logic            s1_v_q, s1_hit_q;
  logic [CNT_W-1:0] cnt_q;
  logic            wipe_per, wipe;

  assign ins_ready_o = !list_full;
  assign vio_go = vio_valid_i && !clr_i;
  assign ins_go = ins_valid_i && ins_store_i && ins_ready_o && ins_hit && !clr_i;
  assign lk_go  = lk_valid_i && !clr_i;
  assign iss_go = iss_valid_i && iss_store_i && !clr_i;
  assign sq_go  = sq_valid_i && !clr_i;

  assign wipe_per = s1_v_q && (cnt_q == CNT_W'(CLEAR_PERIOD - 1));
  assign wipe     = clr_i || wipe_per;

  mdp_id_table #(
    .PC_W(PC_W), .SSIT_DEPTH(SSIT_DEPTH), .LFST_DEPTH(LFST_DEPTH), .PC_OFFSET(PC_OFFSET)
  ) u_ids (
    .clk(clk), .rst(rst), .wipe_i(wipe),
    .vio_valid_i(vio_go), .vio_st_pc_i(vio_st_pc_i), .vio_ld_pc_i(vio_ld_pc_i),
    .rd_pc_a_i(lk_pc_i), .rd_hit_a_o(lk_hit), .rd_id_a_o(lk_id),
    .rd_pc_b_i(ins_pc_i), .rd_hit_b_o(ins_hit), .rd_id_b_o(ins_id)
  );

  mdp_last_store #(.SEQ_W(SEQ_W), .LFST_DEPTH(LFST_DEPTH)) u_last (
    .clk(clk), .rst(rst), .wipe_i(wipe),
    .wr_i(ins_go), .wr_id_i(ins_id), .wr_seq_i(ins_seq_i),
    .drop_mask_i(drop_mask),
    .rd_id_i(lk_id), .rd_hit_o(lf_hit), .rd_seq_o(lf_seq)
  );

  mdp_inflight #(
    .SEQ_W(SEQ_W), .TID_W(TID_W), .LFST_DEPTH(LFST_DEPTH), .DEPTH(LIST_DEPTH)
  ) u_list (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .alloc_i(ins_go), .alloc_seq_i(ins_seq_i), .alloc_tid_i(ins_tid_i), .alloc_id_i(ins_id),
    .iss_i(iss_go), .iss_seq_i(iss_seq_i),
    .sq_i(sq_go), .sq_seq_i(sq_seq_i), .sq_tid_i(sq_tid_i),
    .full_o(list_full), .drop_mask_o(drop_mask)
  );

  // Stage 1: ID table result registered alongside the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v_q   <= 1'b0;
      s1_hit_q <= 1'b0;
    end else begin
      s1_v_q   <= lk_go;
      s1_hit_q <= lk_hit;
    end
  end

  // Stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_seq_o   <= '0;
    end else begin
      rsp_valid_o <= s1_v_q;
      rsp_seq_o   <= (s1_v_q && s1_hit_q && lf_hit) ? lf_seq : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (wipe_per) cnt_q <= '0;
    else if (s1_v_q)   cnt_q <= cnt_q + 1'b1;
  end

  // R11: the prediction count never reaches the period
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(CLEAR_PERIOD));

  // R6: every response traces back to an accepted request two edges earlier
  assert_rsp_origin_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(lk_valid_i, 2));
endmodule

// File: tb/mdp_storeset_bench.sv
`timescale 1ns/1ps
module mdp_storeset_bench;
  localparam int PC_W = 32;
  localparam int SEQ_W = 16;
  localparam int PERIOD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_i = 0, vio_valid_i = 0, ins_valid_i = 0, ins_store_i = 0;
  logic lk_valid_i = 0, iss_valid_i = 0, iss_store_i = 0, sq_valid_i = 0;
  logic [PC_W-1:0] vio_st_pc_i = '0, vio_ld_pc_i = '0, ins_pc_i = '0, lk_pc_i = '0;
  logic [SEQ_W-1:0] ins_seq_i = '0, iss_seq_i = '0, sq_seq_i = '0;
  logic [0:0] ins_tid_i = '0, sq_tid_i = '0;
  logic ins_ready_o, rsp_valid_o;
  logic [SEQ_W-1:0] rsp_seq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdp_storeset #(.CLEAR_PERIOD(PERIOD)) u_mdp_storeset (
    .clk(clk), .rst(rst), .clr_i(clr_i),
    .vio_valid_i(vio_valid_i), .vio_st_pc_i(vio_st_pc_i), .vio_ld_pc_i(vio_ld_pc_i),
    .ins_valid_i(ins_valid_i), .ins_store_i(ins_store_i), .ins_pc_i(ins_pc_i),
    .ins_seq_i(ins_seq_i), .ins_tid_i(ins_tid_i), .ins_ready_o(ins_ready_o),
    .lk_valid_i(lk_valid_i), .lk_pc_i(lk_pc_i),
    .rsp_valid_o(rsp_valid_o), .rsp_seq_o(rsp_seq_o),
    .iss_valid_i(iss_valid_i), .iss_store_i(iss_store_i), .iss_seq_i(iss_seq_i),
    .sq_valid_i(sq_valid_i), .sq_seq_i(sq_seq_i), .sq_tid_i(sq_tid_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr_i = 1;
    @(negedge clk); clr_i = 0;
  endtask

  task automatic do_vio(input logic [31:0] st, input logic [31:0] ld);
    @(negedge clk); vio_valid_i = 1; vio_st_pc_i = st; vio_ld_pc_i = ld;
    @(negedge clk); vio_valid_i = 0;
  endtask

  task automatic do_ins(input logic st, input logic [31:0] pc, input logic [15:0] seq,
                        input logic tid);
    @(negedge clk); ins_valid_i = 1; ins_store_i = st; ins_pc_i = pc;
    ins_seq_i = seq; ins_tid_i = tid;
    @(negedge clk); ins_valid_i = 0;
  endtask

  task automatic do_iss(input logic st, input logic [15:0] seq);
    @(negedge clk); iss_valid_i = 1; iss_store_i = st; iss_seq_i = seq;
    @(negedge clk); iss_valid_i = 0;
  endtask

  task automatic do_sq(input logic [15:0] seq, input logic tid);
    @(negedge clk); sq_valid_i = 1; sq_seq_i = seq; sq_tid_i = tid;
    @(negedge clk); sq_valid_i = 0;
  endtask

  // Response is registered two rising edges after the request edge
  task automatic look(input string req, input logic [31:0] pc, input logic [15:0] exp);
    @(negedge clk); lk_valid_i = 1; lk_pc_i = pc;
    @(negedge clk); lk_valid_i = 0;
    @(negedge clk);
    chk({req, " rsp_valid"}, 32'(rsp_valid_o), 32'd1);
    chk(req, 32'(rsp_seq_o), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R10 ready after reset", 32'(ins_ready_o), 32'd1);
    chk("R6 no response after reset", 32'(rsp_valid_o), 32'd0);
    look("R6 empty table gives 0", 32'h20, 16'd0);
  endtask

  task automatic t_fresh_set();
    do_clr();
    do_vio(32'hC14, 32'h20);
    do_ins(1, 32'hC14, 16'd10, 0);
    look("R2 load joins hashed set", 32'h20, 16'd10);
    look("R5 store with no set not recorded", 32'h48, 16'd0);
    look("R6 store PC itself predicts", 32'hC14, 16'd10);
    look("R1 aliasing PC shares entry", 32'hD14, 16'd10);
  endtask

  task automatic t_load_insert();
    do_clr();
    do_vio(32'hC14, 32'h20);
    do_ins(1, 32'hC14, 16'd10, 0);
    do_ins(0, 32'hC14, 16'd99, 0);
    look("R7 load insert leaves entry", 32'h20, 16'd10);
    chk("R7 load insert takes no slot", 32'(ins_ready_o), 32'd1);
  endtask

  task automatic t_merge_both();
    do_clr();
    do_vio(32'hC14, 32'h20);   // set 7
    do_vio(32'h48, 32'h88);    // set 8
    do_vio(32'hC14, 32'h88);   // both valid: smaller wins
    do_ins(1, 32'h48, 16'd20, 0);
    look("R4 load left larger set", 32'h88, 16'd0);
    do_ins(1, 32'hC14, 16'd21, 0);
    look("R4 load moved to smaller set", 32'h88, 16'd21);
    look("R4 other member unchanged", 32'h20, 16'd21);
  endtask

  task automatic t_merge_one();
    do_clr();
    do_vio(32'hC14, 32'h20);
    do_vio(32'h300, 32'h20);   // store new, load valid
    do_ins(1, 32'h300, 16'd50, 0);
    look("R3 store takes load set", 32'h20, 16'd50);
    do_vio(32'hC14, 32'h88);   // store valid, load new
    look("R3 load takes store set", 32'h88, 16'd50);
  endtask

  task automatic t_issue();
    do_clr();
    do_vio(32'hC14, 32'h20);
    do_ins(1, 32'hC14, 16'd30, 0);
    do_ins(1, 32'hC14, 16'd31, 0);
    do_iss(0, 16'd31);
    look("R8 load issue ignored", 32'h20, 16'd31);
    do_iss(1, 16'd30);
    look("R8 older store issue keeps newer entry", 32'h20, 16'd31);
    do_iss(1, 16'd31);
    look("R8 owner issue clears entry", 32'h20, 16'd0);
  endtask

  task automatic t_squash();
    do_clr();
    do_vio(32'hC14, 32'h20);
    do_vio(32'h48, 32'h88);
    do_ins(1, 32'hC14, 16'd40, 0);
    do_ins(1, 32'h48, 16'd45, 1);
    do_sq(16'd42, 0);
    look("R9 older store survives", 32'h20, 16'd40);
    look("R9 other thread survives", 32'h88, 16'd45);
    do_sq(16'd42, 1);
    look("R9 younger store of thread dropped", 32'h88, 16'd0);
    do_sq(16'd39, 0);
    look("R9 boundary below drops store", 32'h20, 16'd0);
  endtask

  task automatic t_full();
    do_clr();
    do_vio(32'hC14, 32'h20);
    for (int i = 0; i < 8; i++) do_ins(1, 32'hC14, 16'(60 + i), 0);
    chk("R10 ready low when full", 32'(ins_ready_o), 32'd0);
    do_ins(1, 32'hC14, 16'd70, 0);
    look("R10 insert while full ignored", 32'h20, 16'd67);
    do_iss(1, 16'd67);
    chk("R10 ready after issue frees slot", 32'(ins_ready_o), 32'd1);
    look("R8 issue of newest clears entry", 32'h20, 16'd0);
  endtask

  task automatic t_wipe();
    do_clr();
    do_vio(32'hC14, 32'h20);
    do_ins(1, 32'hC14, 16'd80, 0);
    for (int i = 0; i < PERIOD - 1; i++) look("R11 before period", 32'h20, 16'd80);
    look("R11 last prediction pre-wipe", 32'h20, 16'd80);
    look("R11 tables wiped after period", 32'h20, 16'd0);
    do_ins(1, 32'hC14, 16'd81, 0);
    look("R11 store set IDs wiped", 32'h20, 16'd0);
  endtask

  task automatic t_gclear();
    do_clr();
    do_vio(32'hC14, 32'h20);
    for (int i = 0; i < 8; i++) do_ins(1, 32'hC14, 16'(90 + i), 0);
    @(negedge clk); clr_i = 1; ins_valid_i = 1; ins_store_i = 1;
    ins_pc_i = 32'hC14; ins_seq_i = 16'd99;
    @(negedge clk); clr_i = 0; ins_valid_i = 0;
    chk("R12 list emptied", 32'(ins_ready_o), 32'd1);
    look("R12 tables emptied", 32'h20, 16'd0);
    do_ins(1, 32'hC14, 16'd100, 0);
    look("R12 IDs gone after clear", 32'hC14, 16'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_fresh_set();
    t_load_insert();
    t_merge_both();
    t_merge_one();
    t_issue();
    t_squash();
    t_full();
    t_wipe();
    t_gclear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule